// File: doc/BRIEF.md
# Host-to-Processor Command Mailbox

This block is the register window through which a host hands commands to the embedded processor of an acquisition card. The host loads up to `NUM_PARAMS` argument words and a subsystem selector, then writes a command word. The command is latched as pending and a small executor model carries it out after a fixed latency. That latency stands in for the processor's firmware. The executor may write one result word back into the argument area, and then stamps a completion code into the upper byte of the command word.

Completion is reported in-band. The lower byte of the command word keeps the command code. The upper byte reads 0x00 while the command is outstanding, and then 0x55 (success), 0xAA (error) or 0xFF (unknown command). A sticky command-done flag drives an interrupt output, and the host clears that flag by writing to it. The host may poll the command word or wait for the interrupt.

Top module: `mbx_cmd_mailbox`

## Requirements
- R1: After reset every argument word, the subsystem word, the command word and the flag register read 0x0000, and `cmd_done_irq` is low.
- R2: A write to the command word (address `NUM_PARAMS`+1) when no command is pending is accepted at that clock edge. From the next read the word holds the written low byte as the command code and 0x00 in the upper byte. The upper byte of the written data is discarded.
- R3: The completion code appears in the upper byte exactly `EXEC_LAT` clock edges after the accepting edge, and the upper byte stays 0x00 before that. The low byte is never changed by completion.
- R4: A command code outside the set {0..8, 16..19, 32..38, 48} completes with 0xFF, whatever the subsystem word holds.
- R5: A supported command whose subsystem word (latched at acceptance) is greater than 5 completes with 0xAA.
- R6: Command 5 (single read) returns its result in argument word 2 and completes with 0x55. With subsystem 0 the result is {argument 1 bits [3:0], argument 0 bits [11:0]}. With subsystem 2 the result is the last value stored by a successful single write to subsystem 3. Any other subsystem completes with 0xAA and leaves argument word 2 unchanged.
- R7: Command 6 (single write) with subsystem 3 stores argument word 2 as the digital output value and completes with 0x55. Subsystem 1 completes with 0x55 and stores nothing. Subsystems 0, 2, 4 and 5 complete with 0xAA and leave the stored value unchanged.
- R8: Command 0 (board info) with a valid subsystem writes `BOARD_ID` into argument word 0 and completes with 0x55.
- R9: Every other supported command with a valid subsystem completes with 0x55 and leaves all argument words unchanged.
- R10: A write to the command word while a command is pending is ignored. The word keeps its code and its 0x00 status, the original command completes on its original schedule, and the ignored write produces no later command.
- R11: Bit 7 of the flag register (address `NUM_PARAMS`+2) is set on the completion edge and drives `cmd_done_irq`. Writing a 1 to bit 7 clears it and writing a 0 there has no effect. A completion in the same cycle as a clear leaves the flag set.
- R12: Argument words sit at addresses 0 to `NUM_PARAMS`-1 and the subsystem word at `NUM_PARAMS`, all readable as written. Any other address reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | ADDR_W | Word address for reads and writes |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for `host_addr`, combinational |
| cmd_done_irq | output | 1 | Command-done interrupt, mirrors flag bit 7 |

## Verification
Register writes take effect on the edge that samples the strobe. Read data is combinational from the address, so the bench reads on the falling edge after any write. The command word shows code with status 0x00 on the falling edge after the accepting edge. The bench samples it again at `EXEC_LAT`-1 edges to confirm the status is still 0x00. At `EXEC_LAT` edges it expects the completion code, the flag and any result word together. Random commands are followed by the same timed sampling sequence, with expected status and results computed by bench functions that model the digital output value.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam logic [7:0] ST_WAIT  = 8'h00;
  localparam logic [7:0] ST_OK    = 8'h55;
  localparam logic [7:0] ST_ERR   = 8'hAA;
  localparam logic [7:0] ST_UNSUP = 8'hFF;

  localparam logic [7:0] OP_BOARD_INFO = 8'd0;
  localparam logic [7:0] OP_READ_ONE   = 8'd5;
  localparam logic [7:0] OP_WRITE_ONE  = 8'd6;

  localparam int SS_AIN  = 0;
  localparam int SS_AOUT = 1;
  localparam int SS_DIN  = 2;
  localparam int SS_DOUT = 3;
  localparam int SS_LAST = 5;

  localparam int FLAG_DONE_BIT = 7;
  localparam int RES_WORD_IDX  = 2;

  function automatic logic op_known(input logic [7:0] op);
    return (op <= 8'd8) ||
           ((op >= 8'd16) && (op <= 8'd19)) ||
           ((op >= 8'd32) && (op <= 8'd38)) ||
           (op == 8'd48);
  endfunction
endpackage

// File: rtl/mbx_param_store.sv
`timescale 1ns/1ps
module mbx_param_store #(
  parameter int NUM_PARAMS = 32,
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             host_we,
  input  logic [IDX_W-1:0]                 host_idx,
  input  logic [DATA_W-1:0]                host_wdata,
  input  logic                             subsys_we,
  input  logic                             exec_we,
  input  logic [IDX_W-1:0]                 exec_idx,
  input  logic [DATA_W-1:0]                exec_wdata,
  output logic [NUM_PARAMS-1:0][DATA_W-1:0] params,
  output logic [DATA_W-1:0]                subsys
);
  logic [DATA_W-1:0] subsys_q;

  for (genvar i = 0; i < NUM_PARAMS; i++) begin : g_word
    logic              hit_host;
    logic              hit_exec;
    logic              word_en;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    // executor result has priority over a host write to the same word
    always_comb begin
      hit_host = host_we && (host_idx == IDX_W'(i));
      hit_exec = exec_we && (exec_idx == IDX_W'(i));
      word_en  = hit_host || hit_exec;
      word_d   = hit_exec ? exec_wdata : host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign params[i] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subsys_q <= '0;
    end else if (subsys_we) begin
      subsys_q <= host_wdata;
    end
  end

  assign subsys = subsys_q;
endmodule

// File: rtl/mbx_executor.sv
`timescale 1ns/1ps
module mbx_executor
  import mbx_pkg::*;
#(
  parameter int                NUM_PARAMS = 32,
  parameter int                DATA_W     = 16,
  parameter int                IDX_W      = 5,
  parameter int                EXEC_LAT   = 4,
  parameter int                GAIN_W     = 4,
  parameter logic [DATA_W-1:0] BOARD_ID   = 'hB0A7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_we,
  input  logic [DATA_W-1:0]                cmd_wdata,
  input  logic [DATA_W-1:0]                subsys_in,
  input  logic [NUM_PARAMS-1:0][DATA_W-1:0] params,
  output logic                             pending,
  output logic [DATA_W-1:0]                mbx_word,
  output logic                             done,
  output logic                             res_we,
  output logic [IDX_W-1:0]                 res_idx,
  output logic [DATA_W-1:0]                res_wdata
);
  localparam int CODE_W = DATA_W / 2;
  localparam int CNT_W  = (EXEC_LAT > 1) ? $clog2(EXEC_LAT) : 1;
  localparam int CHAN_W = DATA_W - GAIN_W;

  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic [DATA_W-1:0] ss_q, ss_d;
  logic [DATA_W-1:0] dout_q, dout_d;

  logic              accept, finish, ss_valid;
  logic [7:0]        op;
  logic [7:0]        status;
  logic              r_we, dout_we;
  logic [IDX_W-1:0]  r_idx;
  logic [DATA_W-1:0] r_data;

  // command decode, evaluated on the latched code and subsystem
  always_comb begin
    op       = word_q[7:0];
    ss_valid = (ss_q <= DATA_W'(SS_LAST));
    status   = ST_OK;
    r_we     = 1'b0;
    r_idx    = '0;
    r_data   = '0;
    dout_we  = 1'b0;
    if (!op_known(op)) begin
      status = ST_UNSUP;
    end else if (!ss_valid) begin
      status = ST_ERR;
    end else begin
      case (op)
        OP_BOARD_INFO: begin
          r_we   = 1'b1;
          r_idx  = '0;
          r_data = BOARD_ID;
        end
        OP_READ_ONE: begin
          r_idx = IDX_W'(RES_WORD_IDX);
          if (ss_q == DATA_W'(SS_AIN)) begin
            r_we   = 1'b1;
            r_data = {params[1][GAIN_W-1:0], params[0][CHAN_W-1:0]};
          end else if (ss_q == DATA_W'(SS_DIN)) begin
            r_we   = 1'b1;
            r_data = dout_q;
          end else begin
            status = ST_ERR;
          end
        end
        OP_WRITE_ONE: begin
          if (ss_q == DATA_W'(SS_DOUT)) begin
            dout_we = 1'b1;
          end else if (ss_q != DATA_W'(SS_AOUT)) begin
            status = ST_ERR;
          end
        end
        default: status = ST_OK;
      endcase
    end
  end

  // next state
  always_comb begin
    accept = cmd_we && !pend_q;
    finish = pend_q && (cnt_q == '0);
    pend_d = pend_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    ss_d   = ss_q;
    dout_d = dout_q;
    if (accept) begin
      pend_d = 1'b1;
      cnt_d  = CNT_W'(EXEC_LAT - 1);
      word_d = {ST_WAIT, cmd_wdata[CODE_W-1:0]};
      ss_d   = subsys_in;
    end else if (finish) begin
      pend_d = 1'b0;
      word_d = {status, word_q[CODE_W-1:0]};
      if (dout_we) begin
        dout_d = params[RES_WORD_IDX];
      end
    end else if (pend_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
      ss_q   <= '0;
      dout_q <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
      ss_q   <= ss_d;
      dout_q <= dout_d;
    end
  end

  assign pending   = pend_q;
  assign mbx_word  = word_q;
  assign done      = finish;
  assign res_we    = finish && r_we;
  assign res_idx   = r_idx;
  assign res_wdata = r_data;
endmodule

// File: rtl/mbx_cmd_mailbox.sv
`timescale 1ns/1ps
module mbx_cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int                NUM_PARAMS = 32,
  parameter int                DATA_W     = 16,
  parameter int                EXEC_LAT   = 4,
  parameter int                GAIN_W     = 4,
  parameter logic [DATA_W-1:0] BOARD_ID   = 'hB0A7,
  parameter int                ADDR_W     = $clog2(NUM_PARAMS + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cmd_done_irq
);
  localparam int IDX_W = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1;
  localparam logic [ADDR_W-1:0] SUBSYS_ADDR = ADDR_W'(NUM_PARAMS);
  localparam logic [ADDR_W-1:0] MBX_ADDR    = ADDR_W'(NUM_PARAMS + 1);
  localparam logic [ADDR_W-1:0] FLAG_ADDR   = ADDR_W'(NUM_PARAMS + 2);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                              param_we, subsys_we, cmd_we, flag_we;
  logic [IDX_W-1:0]                  host_idx;
  logic [NUM_PARAMS-1:0][DATA_W-1:0] params;
  logic [DATA_W-1:0]                 subsys;
  logic                              pending, done;
  logic [DATA_W-1:0]                 mbx_word;
  logic                              res_we;
  logic [IDX_W-1:0]                  res_idx;
  logic [DATA_W-1:0]                 res_wdata;
  logic                              flag_q, flag_d;

  always_comb begin
    param_we  = host_wr && (host_addr < SUBSYS_ADDR);
    subsys_we = host_wr && (host_addr == SUBSYS_ADDR);
    cmd_we    = host_wr && (host_addr == MBX_ADDR);
    flag_we   = host_wr && (host_addr == FLAG_ADDR);
    host_idx  = IDX_W'(host_addr);
  end

  mbx_param_store #(
    .NUM_PARAMS(NUM_PARAMS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .host_we   (param_we),
    .host_idx  (host_idx),
    .host_wdata(host_wdata),
    .subsys_we (subsys_we),
    .exec_we   (res_we),
    .exec_idx  (res_idx),
    .exec_wdata(res_wdata),
    .params    (params),
    .subsys    (subsys)
  );

  mbx_executor #(
    .NUM_PARAMS(NUM_PARAMS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .EXEC_LAT  (EXEC_LAT),
    .GAIN_W    (GAIN_W),
    .BOARD_ID  (BOARD_ID)
  ) u_exec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_we   (cmd_we),
    .cmd_wdata(host_wdata),
    .subsys_in(subsys),
    .params   (params),
    .pending  (pending),
    .mbx_word (mbx_word),
    .done     (done),
    .res_we   (res_we),
    .res_idx  (res_idx),
    .res_wdata(res_wdata)
  );

  // sticky done flag: completion wins over a same-cycle clear
  always_comb begin
    flag_d = flag_q;
    if (flag_we && host_wdata[FLAG_DONE_BIT]) begin
      flag_d = 1'b0;
    end
    if (done) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr < SUBSYS_ADDR) begin
      host_rdata = params[host_idx];
    end else if (host_addr == SUBSYS_ADDR) begin
      host_rdata = subsys;
    end else if (host_addr == MBX_ADDR) begin
      host_rdata = mbx_word;
    end else if (host_addr == FLAG_ADDR) begin
      host_rdata[FLAG_DONE_BIT] = flag_q;
    end
  end

  assign cmd_done_irq = flag_q;
endmodule

// File: rtl/mbx_cmd_mailbox_chk.sv
`timescale 1ns/1ps
module mbx_cmd_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int EXEC_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pending,
  input logic [DATA_W-1:0] mbx_word,
  input logic              cmd_we,
  input logic              irq
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (pending) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  assert_wait_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (mbx_word[15:8] == ST_WAIT));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> (busy_cnt == 32'(EXEC_LAT)));

  assert_code_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> (mbx_word[15:8] == ST_OK || mbx_word[15:8] == ST_ERR ||
                        mbx_word[15:8] == ST_UNSUP));

  assert_unsup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pending) && !op_known(mbx_word[7:0])) |-> (mbx_word[15:8] == ST_UNSUP));

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && cmd_we) |=> (mbx_word[7:0] == $past(mbx_word[7:0])));

  assert_irq_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> irq);

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(pending));
endmodule

bind mbx_cmd_mailbox mbx_cmd_mailbox_chk #(
  .DATA_W  (DATA_W),
  .EXEC_LAT(EXEC_LAT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .pending (pending),
  .mbx_word(mbx_word),
  .cmd_we  (cmd_we),
  .irq     (cmd_done_irq)
);

// File: tb/mbx_cmd_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_cmd_mailbox_bench;
  localparam int          NP   = 32;
  localparam int          DW   = 16;
  localparam int          LAT  = 4;
  localparam int          AW   = 6;
  localparam logic [15:0] BID  = 16'hB0A7;
  localparam logic [5:0]  A_SS = 6'd32;
  localparam logic [5:0]  A_MB = 6'd33;
  localparam logic [5:0]  A_FL = 6'd34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] model_dout = 16'h0000;

  always #2 clk = ~clk;

  mbx_cmd_mailbox #(.NUM_PARAMS(NP), .DATA_W(DW), .EXEC_LAT(LAT), .GAIN_W(4),
                    .BOARD_ID(BID)) u_mbx_cmd_mailbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_done_irq(irq));

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    host_addr = a;
    #0.1;
    d = host_rdata;
  endtask

  function automatic bit known(input logic [7:0] op);
    return (op < 9) || (op > 15 && op < 20) || (op > 31 && op < 39) || op == 48;
  endfunction

  function automatic logic [7:0] exp_status(input logic [7:0] op, input logic [15:0] ss);
    if (!known(op)) return 8'hFF;
    if (ss > 5) return 8'hAA;
    if (op == 5) return (ss == 0 || ss == 2) ? 8'h55 : 8'hAA;
    if (op == 6) return (ss == 1 || ss == 3) ? 8'h55 : 8'hAA;
    return 8'h55;
  endfunction

  task automatic do_cmd(input logic [15:0] ss, input logic [15:0] cmd,
                        input logic [15:0] p0, input logic [15:0] p1,
                        input logic [15:0] p2, input string tag);
    logic [15:0] v, e0, e2;
    logic [7:0]  op, st;
    op = cmd[7:0];
    st = exp_status(op, ss);
    wr(6'd0, p0); wr(6'd1, p1); wr(6'd2, p2); wr(A_SS, ss);
    wr(A_MB, cmd);
    rd(A_MB, v);
    check(v == {8'h00, op}, {"R2 accept ", tag}, v, {8'h00, op});
    repeat (LAT - 1) @(negedge clk);
    rd(A_MB, v);
    check(v[15:8] == 8'h00 && irq == 1'b0, {"R3 early ", tag}, v, {8'h00, op});
    @(negedge clk);
    rd(A_MB, v);
    check(v == {st, op}, {"R3 status ", tag}, v, {st, op});
    check(irq == 1'b1, {"R11 irq set ", tag}, 16'(irq), 16'd1);
    e0 = (op == 0 && st == 8'h55) ? BID : p0;
    e2 = p2;
    if (op == 5 && st == 8'h55) e2 = (ss == 0) ? {p1[3:0], p0[11:0]} : model_dout;
    if (op == 6 && st == 8'h55 && ss == 3) model_dout = p2;
    rd(6'd0, v);
    check(v == e0, {"R8 word0 ", tag}, v, e0);
    rd(6'd1, v);
    check(v == p1, {"R9 word1 ", tag}, v, p1);
    rd(6'd2, v);
    check(v == e2, {"R6 word2 ", tag}, v, e2);
    wr(A_FL, 16'h0080);
    check(irq == 1'b0, {"R11 irq clear ", tag}, 16'(irq), 16'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
    if (!finished) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 35; a++) begin
      rd(6'(a), v);
      check(v == 16'h0000, "R1 reset word", v, 16'h0000);
    end
    check(irq == 1'b0, "R1 reset irq", 16'(irq), 16'd0);

    // directed corner cases
    do_cmd(16'd0, 16'h0000, 16'h1111, 16'h2222, 16'h3333, "R8 board info");
    do_cmd(16'd0, 16'h0005, 16'hFABC, 16'h0013, 16'h0000, "R6 read AI");
    do_cmd(16'd3, 16'h0006, 16'h0000, 16'h0000, 16'h5A5A, "R7 write DOUT");
    do_cmd(16'd2, 16'h0005, 16'h0000, 16'h0000, 16'h1234, "R6 read DIN");
    do_cmd(16'd1, 16'h0006, 16'h0000, 16'h0000, 16'h7777, "R7 write AO");
    do_cmd(16'd0, 16'h0006, 16'h0000, 16'h0000, 16'h9999, "R7 write AI err");
    do_cmd(16'd2, 16'h0005, 16'h0000, 16'h0000, 16'h4444, "R7 dout kept");
    do_cmd(16'd1, 16'h0005, 16'h0001, 16'h0002, 16'h0003, "R6 read AO err");
    do_cmd(16'd0, 16'h0009, 16'h0001, 16'h0002, 16'h0003, "R4 code 9");
    do_cmd(16'd9, 16'h0031, 16'h0001, 16'h0002, 16'h0003, "R4 code 49 bad ss");
    do_cmd(16'd4, 16'h0030, 16'h0001, 16'h0002, 16'h0003, "R9 halt");
    do_cmd(16'd5, 16'h0026, 16'h0001, 16'h0002, 16'h0003, "R9 code 38");
    do_cmd(16'd5, 16'h0027, 16'h0001, 16'h0002, 16'h0003, "R4 code 39");
    do_cmd(16'd6, 16'h0003, 16'h0001, 16'h0002, 16'h0003, "R5 ss 6");
    do_cmd(16'hFFFF, 16'h0000, 16'h0001, 16'h0002, 16'h0003, "R5 ss max");
    do_cmd(16'd0, 16'h7703, 16'h0001, 16'h0002, 16'h0003, "R2 upper byte dropped");

    // R10 write while pending
    wr(A_SS, 16'd0);
    wr(A_MB, 16'h0003);
    wr(A_MB, 16'h0009);
    rd(A_MB, v);
    check(v == 16'h0003, "R10 busy write ignored", v, 16'h0003);
    repeat (LAT - 2) @(negedge clk);
    rd(A_MB, v);
    check(v == 16'h5503, "R10 original completes", v, 16'h5503);
    wr(A_FL, 16'h0000);
    check(irq == 1'b1, "R11 write zero keeps flag", 16'(irq), 16'd1);
    rd(A_FL, v);
    check(v == 16'h0080, "R11 flag bit7", v, 16'h0080);
    wr(A_FL, 16'h0080);
    repeat (LAT + 2) @(negedge clk);
    rd(A_MB, v);
    check(v == 16'h5503 && irq == 1'b0, "R10 no queued command", v, 16'h5503);

    // R12 map
    wr(A_SS, 16'hC0DE);
    rd(A_SS, v);
    check(v == 16'hC0DE, "R12 subsys readback", v, 16'hC0DE);
    wr(6'd31, 16'hBEEF);
    rd(6'd31, v);
    check(v == 16'hBEEF, "R12 last word", v, 16'hBEEF);
    wr(6'd40, 16'h1234);
    for (int a = 35; a < 64; a++) begin
      rd(6'(a), v);
      check(v == 16'h0000, "R12 unmapped", v, 16'h0000);
    end

    // random commands
    for (int n = 0; n < 300; n++) begin
      logic [15:0] ss, cmd;
      ss  = 16'($urandom % 8);
      cmd = ($urandom % 5 == 0) ? 16'($urandom) : 16'($urandom % 56);
      do_cmd(ss, cmd, 16'($urandom), 16'($urandom), 16'($urandom), "R9 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule